// File: doc/BRIEF.md
# APB Requester Engine

This block turns a simple valid/ready command stream into APB-style bus transfers. Each command holds an address, a write flag, write data, a byte-lane strobe and a three-bit protection field. The engine registers the command and opens a transfer with a setup cycle, in which select is high and enable is low. An access cycle follows with enable high. The access cycle repeats for as long as the completer keeps ready low. Every bus field comes from a register that loads only when a command is accepted, so the fields cannot change during wait states.

Each transfer ends with a one-cycle response strobe. The strobe carries the read data and an error flag, both captured in the completing access cycle. A stall counter bounds the wait: when the completer holds ready low for too many access cycles, the engine drops select and enable and returns a response marked as a timeout error. A new command can be taken in the same cycle a transfer completes. The following setup phase therefore starts at once, with no idle cycle between back-to-back transfers.

Top module: `apb_req_engine`

## Requirements
- R1: psel, penable and rsp_valid are low while rst_n is low, and psel and penable are still low in the first clock cycle after rst_n rises.
- R2: A command accepted at a clock edge (cmd_valid and cmd_ready both high) produces a setup cycle in the next cycle: psel high, penable low, and paddr, pwrite, pwdata, pprot carrying the command's values.
- R3: The cycle after a setup cycle is an access cycle with psel and penable both high.
- R4: psel stays high from the setup cycle until an access cycle with pready high, or until a timeout abort (R10).
- R5: After an access cycle with pready high, penable is low in the next cycle. psel is then high only if a new command was accepted in that completing cycle.
- R6: paddr, pwrite, pprot, pwdata and pstrb hold their values from the setup cycle through every access cycle of the same transfer.
- R7: A write transfer drives pstrb with the command's strobe. A read transfer (pwrite = 0) drives pstrb as all zeros.
- R8: In the cycle after a completing access cycle, rsp_valid is high for exactly one cycle. In that cycle rsp_rdata equals the prdata of the completing cycle, rsp_err equals its pslverr, and rsp_timeout is 0.
- R9: prdata and pslverr are ignored in setup cycles, in access cycles with pready low, and while idle. Only the completing cycle's values reach the response.
- R10: Access cycles with pready low are counted per transfer. The MAX_STALL-th such cycle aborts the transfer: the next cycle has psel and penable low, and a response with rsp_err = 1, rsp_timeout = 1 and rsp_rdata = 0. A completer that raises pready in an access cycle after MAX_STALL-1 stalls completes normally.
- R11: cmd_ready is high when the engine is idle and in an access cycle with pready high. It is low in setup cycles, in stalled access cycles and in the abort cycle, so back-to-back commands start their setup cycles two cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command taken at this edge when cmd_valid is also high |
| cmd_addr | input | ADDR_W | Command address |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | DATA_W | Write data |
| cmd_strb | input | DATA_W/8 | Byte-lane strobe for writes |
| cmd_prot | input | 3 | Protection attributes |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Read data of the finished transfer |
| rsp_err | output | 1 | Completer error or timeout |
| rsp_timeout | output | 1 | Transfer aborted by the stall bound |
| psel | output | 1 | Bus select |
| penable | output | 1 | Bus enable (access phase) |
| paddr | output | ADDR_W | Bus address |
| pwrite | output | 1 | Bus direction |
| pwdata | output | DATA_W | Bus write data |
| pstrb | output | DATA_W/8 | Bus byte strobe |
| pprot | output | 3 | Bus protection |
| pready | input | 1 | Completer ready |
| prdata | input | DATA_W | Completer read data |
| pslverr | input | 1 | Completer error |

## Verification
The bench builds the engine with ADDR_W = 12, DATA_W = 16 (two strobe lanes) and MAX_STALL = 4. The small stall bound makes a timeout cost only four wait cycles. It also puts the edge case, a completer that answers after exactly three stalls, right beside an abort, so both sides of R10 are exercised many times in a short run. The completer model drives junk read data and a raised error on every cycle that does not complete, which tests R9. Paired zero-wait commands show the two-cycle setup spacing.

// File: rtl/apb_req_pkg.sv
`timescale 1ns/1ps
package apb_req_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } apb_phase_e;
endpackage

// File: rtl/apb_req_hold.sv
`timescale 1ns/1ps
// Request register: loads the bus fields on command acceptance only.
module apb_req_hold #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STRB_W-1:0] strb_i,
  input  logic [2:0]        prot_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              write_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [STRB_W-1:0] strb_o,
  output logic [2:0]        prot_o
);
  logic [STRB_W-1:0] strb_d;

  // reads carry no active lanes
  always_comb strb_d = write_i ? strb_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o  <= '0;
      write_o <= 1'b0;
      wdata_o <= '0;
      strb_o  <= '0;
      prot_o  <= '0;
    end else if (load_i) begin
      addr_o  <= addr_i;
      write_o <= write_i;
      wdata_o <= wdata_i;
      strb_o  <= strb_d;
      prot_o  <= prot_i;
    end
  end
endmodule

// File: rtl/apb_req_stall.sv
`timescale 1ns/1ps
// Counts stalled access cycles; flags the last one allowed.
module apb_req_stall #(
  parameter int MAX_STALL = 16,
  localparam int CW = (MAX_STALL > 1) ? $clog2(MAX_STALL) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic count_i,
  output logic at_limit_o
);
  localparam logic [CW-1:0] LAST = CW'(MAX_STALL - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clear_i | count_i;
    cnt_d  = clear_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb at_limit_o = (cnt_q == LAST);
endmodule

// File: rtl/apb_req_seq.sv
`timescale 1ns/1ps
// Transfer sequencer: idle -> setup -> access (repeats while stalled).
module apb_req_seq
  import apb_req_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid_i,
  input  logic       pready_i,
  input  logic       at_limit_i,
  output apb_phase_e phase_o,
  output logic       cmd_open_o,
  output logic       take_o,
  output logic       done_o,
  output logic       abort_o
);
  apb_phase_e phase_q, phase_d;

  always_comb begin
    done_o     = (phase_q == PH_ACCESS) && pready_i;
    abort_o    = (phase_q == PH_ACCESS) && !pready_i && at_limit_i;
    cmd_open_o = (phase_q == PH_IDLE) || done_o;
    take_o     = cmd_open_o && cmd_valid_i;
  end

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (take_o) phase_d = PH_SETUP;
      PH_SETUP:  phase_d = PH_ACCESS;
      PH_ACCESS: begin
        if (done_o)       phase_d = take_o ? PH_SETUP : PH_IDLE;
        else if (abort_o) phase_d = PH_IDLE;
      end
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  always_comb phase_o = phase_q;
endmodule

// File: rtl/apb_req_engine.sv
`timescale 1ns/1ps
module apb_req_engine
  import apb_req_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_STALL = 16,
  localparam int STRB_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [STRB_W-1:0] cmd_strb,
  input  logic [2:0]        cmd_prot,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              rsp_timeout,
  output logic              psel,
  output logic              penable,
  output logic [ADDR_W-1:0] paddr,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  output logic [STRB_W-1:0] pstrb,
  output logic [2:0]        pprot,
  input  logic              pready,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pslverr
);
  apb_phase_e phase;
  logic       take, done, abort, at_limit;
  logic       in_access, stall_clr, stall_inc, rsp_load;

  apb_req_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid),
    .pready_i    (pready),
    .at_limit_i  (at_limit),
    .phase_o     (phase),
    .cmd_open_o  (cmd_ready),
    .take_o      (take),
    .done_o      (done),
    .abort_o     (abort)
  );

  always_comb begin
    in_access = (phase == PH_ACCESS);
    stall_clr = !in_access;
    stall_inc = in_access && !pready;
    rsp_load  = done || abort;
  end

  apb_req_stall #(.MAX_STALL(MAX_STALL)) u_stall (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (stall_clr),
    .count_i    (stall_inc),
    .at_limit_o (at_limit)
  );

  apb_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (take),
    .addr_i  (cmd_addr),
    .write_i (cmd_write),
    .wdata_i (cmd_wdata),
    .strb_i  (cmd_strb),
    .prot_i  (cmd_prot),
    .addr_o  (paddr),
    .write_o (pwrite),
    .wdata_o (pwdata),
    .strb_o  (pstrb),
    .prot_o  (pprot)
  );

  always_comb begin
    psel    = (phase != PH_IDLE);
    penable = in_access;
  end

  // response stage: strobe every cycle, payload under enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= rsp_load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata   <= '0;
      rsp_err     <= 1'b0;
      rsp_timeout <= 1'b0;
    end else if (rsp_load) begin
      rsp_rdata   <= abort ? '0 : prdata;
      rsp_err     <= abort | pslverr;
      rsp_timeout <= abort;
    end
  end
endmodule

// File: rtl/apb_req_engine_chk.sv
`timescale 1ns/1ps
module apb_req_engine_chk #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_STALL = 16,
  localparam int STRB_W   = DATA_W / 8,
  localparam int CW       = (MAX_STALL > 1) ? $clog2(MAX_STALL) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic              rsp_timeout,
  input logic              psel,
  input logic              penable,
  input logic [ADDR_W-1:0] paddr,
  input logic              pwrite,
  input logic [DATA_W-1:0] pwdata,
  input logic [STRB_W-1:0] pstrb,
  input logic [2:0]        pprot,
  input logic              pready,
  input logic [DATA_W-1:0] prdata,
  input logic              pslverr
);
  localparam logic [CW-1:0] LAST = CW'(MAX_STALL - 1);

  logic          up_q;
  logic [CW-1:0] wait_q;
  logic          stalled, to_now, fin_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= 1'b1;
  end

  always_comb begin
    stalled = psel && penable && !pready;
    to_now  = stalled && (wait_q == LAST);
    fin_now = psel && penable && pready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wait_q <= '0;
    else if (stalled) wait_q <= wait_q + 1'b1;
    else              wait_q <= '0;
  end

  // R1
  first_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_q |-> (!psel && !penable && !rsp_valid));
  // R2
  setup_enable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(psel) |-> !penable);
  // R3
  access_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |=> (psel && penable));
  // R4
  select_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !fin_now && !to_now) |=> psel);
  // R5
  enable_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_now |=> !penable);
  // R6
  fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !fin_now && !to_now) |=> ($stable(paddr) && $stable(pwrite) &&
      $stable(pprot) && $stable(pwdata) && $stable(pstrb)));
  // R7
  read_strobe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite) |-> (pstrb == '0));
  // R8
  response_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_now |=> (rsp_valid && (rsp_rdata == $past(prdata)) &&
      (rsp_err == $past(pslverr)) && !rsp_timeout));
  // R8
  response_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R10
  timeout_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_now |=> (!psel && !penable && rsp_valid && rsp_err && rsp_timeout &&
      (rsp_rdata == '0)));
  // R11
  ready_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!psel || fin_now));
  // R11
  idle_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !psel |-> cmd_ready);
  // R2
  take_starts_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (psel && !penable));
endmodule

bind apb_req_engine apb_req_engine_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_STALL(MAX_STALL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
  .rsp_timeout(rsp_timeout), .psel(psel), .penable(penable), .paddr(paddr),
  .pwrite(pwrite), .pwdata(pwdata), .pstrb(pstrb), .pprot(pprot),
  .pready(pready), .prdata(prdata), .pslverr(pslverr)
);

// File: tb/tb_apb_req_engine.sv
`timescale 1ns/1ps
module tb_apb_req_engine;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int SW = DW / 8;
  localparam int MS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic          cmd_write = 1'b0;
  logic [DW-1:0] cmd_wdata = '0;
  logic [SW-1:0] cmd_strb = '0;
  logic [2:0]    cmd_prot = '0;
  logic          rsp_valid, rsp_err, rsp_timeout;
  logic [DW-1:0] rsp_rdata;
  logic          psel, penable, pwrite;
  logic [AW-1:0] paddr;
  logic [DW-1:0] pwdata;
  logic [SW-1:0] pstrb;
  logic [2:0]    pprot;
  logic          pready = 1'b0;
  logic [DW-1:0] prdata = '0;
  logic          pslverr = 1'b0;

  always #2 clk = ~clk;

  apb_req_engine #(.ADDR_W(AW), .DATA_W(DW), .MAX_STALL(MS)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_wdata(cmd_wdata),
    .cmd_strb(cmd_strb), .cmd_prot(cmd_prot), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .rsp_timeout(rsp_timeout),
    .psel(psel), .penable(penable), .paddr(paddr), .pwrite(pwrite),
    .pwdata(pwdata), .pstrb(pstrb), .pprot(pprot), .pready(pready),
    .prdata(prdata), .pslverr(pslverr)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic          wr;
    logic [DW-1:0] wdata;
    logic [SW-1:0] strb;
    logic [2:0]    prot;
    int            waits;
    logic          err;
    logic [DW-1:0] rdata;
  } job_t;

  typedef struct {
    logic [DW-1:0] rdata;
    logic          err;
    logic          to;
  } exp_t;

  job_t jobq[$];
  exp_t expq[$];
  int   total = 0;
  int   bad = 0;
  int   cyc = 0;
  int   last_setup = 0;
  int   last_gap = 0;
  bit   finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: queues the completer's plan and the scoreboard's expectation
  task automatic send(input job_t j);
    exp_t e;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_addr  = j.addr;
    cmd_write = j.wr;
    cmd_wdata = j.wdata;
    cmd_strb  = j.strb;
    cmd_prot  = j.prot;
    jobq.push_back(j);
    e.to    = (j.waits >= MS);
    e.err   = e.to ? 1'b1 : j.err;
    e.rdata = e.to ? '0 : j.rdata;
    expq.push_back(e);
    #1;
    while (!cmd_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic release_cmd();
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic job_t mk(logic [AW-1:0] a, logic w, logic [DW-1:0] d,
                              logic [SW-1:0] s, logic [2:0] p, int wt,
                              logic er, logic [DW-1:0] rd);
    job_t j;
    j.addr = a; j.wr = w; j.wdata = d; j.strb = s; j.prot = p;
    j.waits = wt; j.err = er; j.rdata = rd;
    return j;
  endfunction

  // completer model with bus-side checks
  job_t cur;
  int   acc = 0;
  bit   prev_setup = 0, prev_stall = 0, prev_abort = 0, prev_done = 0;
  always begin
    bit exp_open, rdy, tout, is_setup;
    @(negedge clk);
    exp_open = 1'b1; rdy = 1'b0; tout = 1'b0; is_setup = 1'b0;
    if (rst_n && psel && !penable) begin
      is_setup = 1'b1;
      exp_open = 1'b0;
      if (jobq.size() == 0) chk("R2", "setup without command", 1, 0);
      else cur = jobq.pop_front();
      acc = 0;
      last_gap = cyc - last_setup;
      last_setup = cyc;
      chk("R2", "setup paddr", paddr, cur.addr);
      chk("R2", "setup pwrite", pwrite, cur.wr);
      chk("R2", "setup pprot", pprot, cur.prot);
      if (cur.wr) chk("R2", "setup pwdata", pwdata, cur.wdata);
      chk("R7", "pstrb", pstrb, cur.wr ? cur.strb : '0);
      pready = 1'b0; pslverr = 1'b1; prdata = 16'hbad0;
    end else if (rst_n && psel && penable) begin
      chk("R6", "held paddr", paddr, cur.addr);
      chk("R6", "held pwrite", pwrite, cur.wr);
      chk("R6", "held pprot", pprot, cur.prot);
      chk("R6", "held pstrb", pstrb, cur.wr ? cur.strb : '0);
      if (cur.wr) chk("R6", "held pwdata", pwdata, cur.wdata);
      rdy  = (acc == cur.waits);
      tout = !rdy && (acc == MS - 1);
      exp_open = rdy;
      pready  = rdy;
      pslverr = rdy ? cur.err : 1'b1;
      prdata  = rdy ? cur.rdata : ~cur.rdata;
      acc++;
    end else begin
      pready = 1'b0; pslverr = 1'b1; prdata = 16'h5a5a;
    end
    #1;
    if (rst_n) begin
      if (prev_setup) chk("R3", "access after setup", {psel, penable}, 2'b11);
      if (prev_stall) chk("R4", "select held in stall", psel, 1);
      if (prev_abort) chk("R10", "bus released after abort", {psel, penable}, 2'b00);
      if (prev_done)  chk("R5", "enable low after completion", penable, 0);
      chk("R11", "cmd_ready", cmd_ready, exp_open);
    end
    prev_setup = is_setup;
    prev_stall = psel && penable && !rdy && !tout;
    prev_abort = tout;
    prev_done  = rdy;
  end

  // scoreboard monitor
  always begin
    exp_t e;
    @(negedge clk);
    #1;
    if (rst_n && rsp_valid) begin
      if (expq.size() == 0) chk("R8", "unexpected response", 1, 0);
      else begin
        e = expq.pop_front();
        chk(e.to ? "R10" : "R8", "rsp_err", rsp_err, e.err);
        chk(e.to ? "R10" : "R8", "rsp_timeout", rsp_timeout, e.to);
        chk(e.to ? "R10" : "R9", "rsp_rdata", rsp_rdata, e.rdata);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk("WD", "watchdog expired", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "psel in reset", psel, 0);
    chk("R1", "penable in reset", penable, 0);
    chk("R1", "rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    #1;
    chk("R1", "psel first cycle after reset", psel, 0);
    chk("R1", "penable first cycle after reset", penable, 0);

    // R8 plain write, no wait
    send(mk(12'h104, 1'b1, 16'h1234, 2'b11, 3'd2, 0, 1'b0, 16'h0f0f));
    release_cmd(); drain();
    // R9 read with two stalls, junk data while stalled
    send(mk(12'h200, 1'b0, 16'hffff, 2'b11, 3'd1, 2, 1'b0, 16'hbeef));
    release_cmd(); drain();
    // R8 completer error
    send(mk(12'h0a8, 1'b0, 16'h0, 2'b01, 3'd0, 0, 1'b1, 16'h7777));
    release_cmd(); drain();
    // R10 boundary: MS-1 stalls, completes normally
    send(mk(12'h3fc, 1'b1, 16'hcafe, 2'b10, 3'd5, MS - 1, 1'b0, 16'h2222));
    release_cmd(); drain();
    // R10 timeout
    send(mk(12'h010, 1'b0, 16'h0, 2'b00, 3'd7, 99, 1'b0, 16'h3333));
    release_cmd(); drain();
    // R11 back-to-back, zero wait
    send(mk(12'h020, 1'b1, 16'haaaa, 2'b01, 3'd3, 0, 1'b0, 16'h4444));
    send(mk(12'h024, 1'b0, 16'h5555, 2'b10, 3'd4, 0, 1'b0, 16'h6666));
    release_cmd(); drain();
    chk("R11", "setup spacing back-to-back", last_gap, 2);
    // mixed stream, timeouts included
    for (int i = 0; i < 24; i++) begin
      send(mk(AW'($urandom), 1'($urandom), DW'($urandom), SW'($urandom),
              3'($urandom), int'($urandom_range(0, 5)), 1'($urandom),
              DW'($urandom)));
    end
    release_cmd(); drain();
    chk("R8", "responses outstanding", expq.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule